// File: doc/BRIEF.md
# Indexed Byte Read-Modify-Write Logic Unit

This unit carries out a single logical operation on one byte held in memory. The caller supplies four things: an operation code, an 8-bit immediate, an index value and a base value. The byte lives at the sum of the index and the base, and that sum wraps at the address width. The unit always reads that byte first. The bitwise operations (AND, XOR, OR) combine the byte with the immediate and write the result back to the same address. The test operation writes nothing. It only produces a new flag bit, which is set when the byte ANDed with the immediate is zero.

The unit drives a simple byte memory port. The port has a request, a write enable, an address, write data, read data and a ready signal. Every access is held steady until ready is seen at a clock edge. When the whole sequence has finished, the unit raises a one-cycle done pulse and presents the resulting flag. A start that arrives while an operation is in flight is ignored.

Top module: `byte_rmw_unit`

## Requirements
- R1: While reset is high and after it is released, `done`, `mem_req`, `mem_we` and `flag_out` are all 0.
- R2: Every memory access of an operation uses the address (`idx_val` + `base_val`) mod 2^ADDR_W, sampled at start.
- R3: The first access of every operation is a read (`mem_we` = 0), and exactly one read is made per operation.
- R4: With `op` = 2'b01 (AND), the byte read ANDed with `imm` is written back to the same address.
- R5: With `op` = 2'b10 (XOR), the byte read XORed with `imm` is written back to the same address.
- R6: With `op` = 2'b11 (OR), the byte read ORed with `imm` is written back to the same address.
- R7: With `op` = 2'b00 (test), no write is made, and `flag_out` becomes 1 exactly when (byte read AND `imm`) is zero.
- R8: For the AND, XOR and OR operations, `flag_out` equals `flag_in` as sampled at start.
- R9: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R10: `done` is a one-cycle pulse that follows the last access, and `mem_req` is low while it is high.
- R11: A `start` that arrives while an operation is in progress is ignored, so it causes no extra access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 2 | 00 test, 01 AND, 10 XOR, 11 OR |
| imm | input | 8 | Immediate operand |
| idx_val | input | ADDR_W | Index register value |
| base_val | input | ADDR_W | Base register value |
| flag_in | input | 1 | Current flag bit |
| flag_out | output | 1 | Resulting flag bit |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with ready on a read |
| mem_ready | input | 1 | Access completes at this clock edge |

## Verification
The bench builds the unit with ADDR_W = 8. With that setting a 256-byte array covers the whole address space. Index and base pairs whose sum passes 255 then exercise the wrap, and every byte the unit could write stays visible to the bench. Each of the four operations is swept over a set of arithmetic data and immediate patterns, including all-zero and all-one values. Memory latencies of zero to two wait cycles are applied, which holds each access across waits. One run injects a second start in the middle of an operation.

// File: rtl/brmw_pkg.sv
package brmw_pkg;
  typedef enum logic [1:0] {
    OP_TEST = 2'b00,
    OP_AND  = 2'b01,
    OP_XOR  = 2'b10,
    OP_OR   = 2'b11
  } brmw_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_READ  = 2'b01,
    ST_WRITE = 2'b10,
    ST_DONE  = 2'b11
  } brmw_state_e;
endpackage

// File: rtl/brmw_addr_gen.sv
module brmw_addr_gen #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] idx_val,
  input  logic [ADDR_W-1:0] base_val,
  output logic [ADDR_W-1:0] eff_addr
);
  // Sum truncated to the address width: wraps modulo 2^ADDR_W.
  assign eff_addr = idx_val + base_val;
endmodule

// File: rtl/brmw_logic_alu.sv
module brmw_logic_alu
  import brmw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  brmw_op_e          op,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] mem_byte,
  output logic [DATA_W-1:0] result,
  output logic              masked_zero
);
  logic [DATA_W-1:0] and_v;

  assign and_v       = mem_byte & operand;
  assign masked_zero = (and_v == '0);

  always_comb begin
    unique case (op)
      OP_AND:  result = and_v;
      OP_XOR:  result = mem_byte ^ operand;
      OP_OR:   result = mem_byte | operand;
      default: result = mem_byte;
    endcase
  end
endmodule

// File: rtl/brmw_seq.sv
module brmw_seq
  import brmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  brmw_op_e          op,
  input  logic [DATA_W-1:0] imm,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic              flag_in,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_zero,
  output brmw_op_e          op_q,
  output logic [DATA_W-1:0] imm_q,
  output logic              flag_out,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready
);
  brmw_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= OP_TEST;
      imm_q     <= '0;
      flag_out  <= 1'b0;
      done      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            op_q     <= op;
            imm_q    <= imm;
            mem_addr <= eff_addr;
            flag_out <= flag_in;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            state    <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ready) begin
            if (op_q == OP_TEST) begin
              flag_out <= alu_zero;
              mem_req  <= 1'b0;
              done     <= 1'b1;
              state    <= ST_DONE;
            end else begin
              mem_we    <= 1'b1;
              mem_wdata <= alu_result;
              state     <= ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          if (mem_ready) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            done    <= 1'b1;
            state   <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))) // R9
    else $error("request dropped or changed before ready");

  AST_FIRST_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> !mem_we) // R3
    else $error("operation began with a write");

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && op_q == OP_TEST) |-> !mem_we) // R7
    else $error("test operation issued a write");

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) // R10
    else $error("done longer than one cycle");

  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req) // R10
    else $error("request active during done");

  AST_IDLE_DONE_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> (state == ST_IDLE)) // R11
    else $error("sequencer failed to return to idle");
endmodule

// File: rtl/byte_rmw_unit.sv
module byte_rmw_unit
  import brmw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [7:0]        imm,
  input  logic [ADDR_W-1:0] idx_val,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              flag_in,
  output logic              flag_out,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ready
);
  localparam int DATA_W = 8;

  logic [ADDR_W-1:0] eff_addr;
  brmw_op_e          op_q;
  logic [DATA_W-1:0] imm_q;
  logic [DATA_W-1:0] alu_result;
  logic              alu_zero;

  brmw_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .idx_val  (idx_val),
    .base_val (base_val),
    .eff_addr (eff_addr)
  );

  brmw_logic_alu #(.DATA_W(DATA_W)) u_alu (
    .op          (op_q),
    .operand     (imm_q),
    .mem_byte    (mem_rdata),
    .result      (alu_result),
    .masked_zero (alu_zero)
  );

  brmw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .op         (brmw_op_e'(op)),
    .imm        (imm),
    .eff_addr   (eff_addr),
    .flag_in    (flag_in),
    .alu_result (alu_result),
    .alu_zero   (alu_zero),
    .op_q       (op_q),
    .imm_q      (imm_q),
    .flag_out   (flag_out),
    .done       (done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready)
  );

  AST_RST_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!done && !mem_req && !mem_we && !flag_out)) // R1
    else $error("outputs not cleared by reset");
endmodule

// File: tb/sim_byte_rmw_unit.sv
module sim_byte_rmw_unit;
  localparam int AW = 8;
  localparam int MSZ = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] imm = 8'h00;
  logic [AW-1:0] idx_val = '0;
  logic [AW-1:0] base_val = '0;
  logic flag_in = 1'b0;
  logic flag_out, done, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  logic mem_ready = 1'b0;

  int checks = 0;
  int fails = 0;
  int latency = 0;
  int wait_cnt = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int bad_addr = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [7:0] mem [MSZ];

  always #5 clk = ~clk;

  byte_rmw_unit #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .imm(imm),
    .idx_val(idx_val), .base_val(base_val), .flag_in(flag_in),
    .flag_out(flag_out), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  // Memory model: ready after `latency` wait cycles, one idle gap after each handshake.
  always @(negedge clk) begin
    if (!mem_req || mem_ready) begin
      wait_cnt = 0;
      mem_ready = 1'b0;
    end else if (wait_cnt >= latency) begin
      mem_ready = 1'b1;
      mem_rdata = mem[mem_addr];
    end else begin
      wait_cnt = wait_cnt + 1;
    end
  end

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (mem_addr != exp_addr) bad_addr = bad_addr + 1;
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt = wr_cnt + 1;
      end else begin
        rd_cnt = rd_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [7:0] im, input logic [7:0] dat,
                        input logic [AW-1:0] ix, input logic [AW-1:0] bs,
                        input logic fin, input int lat, input bit extra_start);
    logic [AW-1:0] a;
    logic [7:0] exp_byte;
    logic exp_flag;
    int n;
    a = ix + bs;
    exp_addr = a;
    latency = lat;
    mem[a] = dat;
    rd_cnt = 0;
    wr_cnt = 0;
    bad_addr = 0;
    case (o)
      2'b01: exp_byte = dat & im;
      2'b10: exp_byte = dat ^ im;
      2'b11: exp_byte = dat | im;
      default: exp_byte = dat;
    endcase
    exp_flag = (o == 2'b00) ? ((dat & im) == 8'h00) : fin;
    @(negedge clk);
    op = o; imm = im; idx_val = ix; base_val = bs; flag_in = fin; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    flag_in = ~fin;
    op = ~o; imm = ~im; idx_val = ~ix;
    if (extra_start) begin
      @(negedge clk);
      start = 1'b1; op = 2'b10; imm = 8'hFF;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 50) begin
      @(negedge clk);
      n = n + 1;
    end
    check(done == 1'b1, "R10 done seen", int'(done), 1);
    check(mem_req == 1'b0, "R10 no request with done", int'(mem_req), 0);
    check(bad_addr == 0, "R2 address", bad_addr, 0);
    check(rd_cnt == 1, "R3 one read", rd_cnt, 1);
    check(wr_cnt == ((o == 2'b00) ? 0 : 1), "R7 write count", wr_cnt, (o == 2'b00) ? 0 : 1);
    case (o)
      2'b00: check(flag_out == exp_flag, "R7 flag", int'(flag_out), int'(exp_flag));
      default: check(flag_out == exp_flag, "R8 flag kept", int'(flag_out), int'(exp_flag));
    endcase
    case (o)
      2'b01: check(mem[a] == exp_byte, "R4 AND result", int'(mem[a]), int'(exp_byte));
      2'b10: check(mem[a] == exp_byte, "R5 XOR result", int'(mem[a]), int'(exp_byte));
      2'b11: check(mem[a] == exp_byte, "R6 OR result", int'(mem[a]), int'(exp_byte));
      default: check(mem[a] == exp_byte, "R7 byte untouched", int'(mem[a]), int'(exp_byte));
    endcase
    @(negedge clk);
    check(done == 1'b0, "R10 single-cycle done", int'(done), 0);
    if (extra_start)
      check(rd_cnt == 1 && wr_cnt == ((o == 2'b00) ? 0 : 1), "R11 start ignored",
            rd_cnt + wr_cnt, (o == 2'b00) ? 1 : 2);
  endtask

  initial begin
    for (int i = 0; i < MSZ; i++) mem[i] = 8'(i * 3 + 1);
    repeat (3) @(negedge clk);
    check(done == 0 && mem_req == 0 && mem_we == 0 && flag_out == 0, "R1 reset",
          {done, mem_req, mem_we, flag_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 0 && mem_req == 0 && mem_we == 0 && flag_out == 0, "R1 after reset",
          {done, mem_req, mem_we, flag_out}, 0);
    for (int o = 0; o < 4; o++) begin
      for (int k = 0; k < 10; k++) begin
        logic [7:0] d, im;
        logic [AW-1:0] ix, bs;
        d  = 8'(k * 37 + o * 11 + 5);
        im = 8'(k * 73 + 19);
        if (k == 0) begin d = 8'hFF; im = 8'h00; end
        if (k == 1) begin d = 8'h00; im = 8'hFF; end
        if (k == 2) begin d = 8'hA5; im = 8'h5A; end
        if (k == 3) begin d = 8'hFF; im = 8'hFF; end
        ix = AW'(k * 59 + o * 17);
        bs = AW'(200 + k * 13);
        run_op(2'(o), im, d, ix, bs, k[0], k % 3, 1'b0);
      end
    end
    run_op(2'b01, 8'h0F, 8'h3C, 8'hF0, 8'h20, 1'b1, 2, 1'b1);
    run_op(2'b00, 8'h80, 8'h7F, 8'hFF, 8'h01, 1'b0, 2, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails = fails + 1;
    checks = checks + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule